// File: doc/BRIEF.md
# Pipelined RGB to YCbCr Colour-Space Converter

This block turns one gamma-corrected RGB pixel per clock into luma and two colour-difference components, all 8 bits wide. Each output component is a fixed-point weighted sum of the three inputs. The two chroma components are then lifted to mid-scale, rounded, and limited to the representable range. One static input chooses between a standard-definition weight matrix and a high-definition weight matrix.

The datapath has three register stages: products, then the sum, then round and clamp. The pixel-valid flag and both sync flags pass through a matching three-stage delay, so every output pixel arrives with its own sideband. The block sits in a video pipeline after the pixel source and ahead of whatever packs or subsamples the chroma.

Top module: `rgb_ycc_pipe`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is zero after that edge: `out_valid`, `out_hs`, `out_vs`, `out_y`, `out_cb` and `out_cr`.
- R2: `out_valid`, `out_hs` and `out_vs` equal `in_valid`, `in_hs` and `in_vs` as sampled three rising edges earlier. The data outputs after that third edge belong to that same input pixel. Back-to-back pixels stream at one per clock.
- R3: With the SD matrix, luma uses the weights 306, 601 and 117 for R, G and B, at a scale of 1024.
- R4: With the SD matrix, Cb uses the weights -176, -347 and 523, and Cr uses 523, -438 and -85, for R, G and B, at a scale of 1024.
- R5: With the HD matrix, luma uses the weights 218, 732 and 74 for R, G and B, at a scale of 1024.
- R6: With the HD matrix, Cb uses the weights -120, -403 and 523, and Cr uses 523, -475 and -48, for R, G and B, at a scale of 1024.
- R7: Each output is floor((S + K + 512) / 1024), where S is the weighted sum. K is 0 for luma and 128*1024 for both chroma components. Floor applies to negative values too.
- R8: A result below 0 is output as 0, and a result above 255 is output as 255.
- R9: `hd_sel` = 1 selects the HD matrix and 0 selects SD. A pixel uses the `hd_sel` value from the latest edge at which `in_valid` was low. A pixel that arrives with no such edge since reset uses SD. Changes of `hd_sel` while `in_valid` stays high have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hd_sel | input | 1 | Matrix select: 1 = HD, 0 = SD; taken only while `in_valid` is low |
| in_valid | input | 1 | Input pixel valid |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync |
| in_r | input | 8 | Red sample |
| in_g | input | 8 | Green sample |
| in_b | input | 8 | Blue sample |
| out_valid | output | 1 | Output pixel valid, delayed three cycles |
| out_hs | output | 1 | Horizontal sync, delayed three cycles |
| out_vs | output | 1 | Vertical sync, delayed three cycles |
| out_y | output | 8 | Luma |
| out_cb | output | 8 | Blue colour difference, offset by 128 |
| out_cr | output | 8 | Red colour difference, offset by 128 |

## Verification
The hardest case to reach is a change of `hd_sel` in the middle of an unbroken run of valid pixels. The change must not reach the pixels of that run, and it must take effect once a blanking cycle occurs. The stimulus toggles `hd_sel` inside a long valid burst and inserts a single low-valid cycle afterwards. It also holds `hd_sel` high through a reset release and starts streaming at once, which checks that the matrix falls back to SD. Saturating colours (pure blue, yellow, cyan) drive the chroma sums past both ends of the range, which exercises the clamp.

// File: rtl/ycc_pkg.sv
// Package: shared coefficient types and the two fixed weight matrices.
// Assumes: weights are signed integers at a scale of 2**CF_FRAC.
package ycc_pkg;
    localparam int CF_FRAC = 10;
    localparam int CF_W    = 12;

    typedef logic signed [CF_W-1:0] coef_t;

    typedef struct packed {
        coef_t kr;
        coef_t kg;
        coef_t kb;
    } coef_row_t;

    // Row 0 = luma, row 1 = Cb, row 2 = Cr
    typedef coef_row_t [2:0] coef_mat_t;

    // Returns the weight matrix for the chosen format (1 = HD)
    function automatic coef_mat_t pick_matrix(input logic hd);
        coef_mat_t m;
        if (hd) begin
            m[0] = '{kr: 12'sd218,  kg: 12'sd732,  kb: 12'sd74};
            m[1] = '{kr: -12'sd120, kg: -12'sd403, kb: 12'sd523};
            m[2] = '{kr: 12'sd523,  kg: -12'sd475, kb: -12'sd48};
        end else begin
            m[0] = '{kr: 12'sd306,  kg: 12'sd601,  kb: 12'sd117};
            m[1] = '{kr: -12'sd176, kg: -12'sd347, kb: 12'sd523};
            m[2] = '{kr: 12'sd523,  kg: -12'sd438, kb: -12'sd85};
        end
        return m;
    endfunction
endpackage

// File: rtl/ycc_mode_reg.sv
// Module: holds the format select and presents the matching weight matrix.
// Assumes: hd_sel is static during active video; it is loaded only on
// cycles where in_valid is low, so a line never switches matrices midway.
module ycc_mode_reg
    import ycc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  logic      hd_sel,
    output coef_mat_t coefs
);
    logic mode_q;

    // Load the select during blanking only; reset falls back to SD
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= 1'b0;
        else if (!in_valid)
            mode_q <= hd_sel;
    end

    // Map the held select onto the constant weight table
    always_comb coefs = pick_matrix(mode_q);

    // R9: the held mode cannot move across an edge where valid was high
    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> $stable(mode_q));
endmodule

// File: rtl/ycc_lane.sv
// Module: one output component; three weighted products, a biased sum,
// then floor-shift and clamp. Three register stages.
// Assumes: inputs are unsigned DATA_W-bit samples; OFFSET is in output units.
module ycc_lane
    import ycc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OFFSET = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  coef_row_t         k,
    input  logic [DATA_W-1:0] r,
    input  logic [DATA_W-1:0] g,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] q
);
    localparam int PROD_W = DATA_W + CF_W + 1;
    localparam int ACC_W  = PROD_W + 2;
    localparam logic signed [ACC_W-1:0] BIAS =
        ACC_W'((OFFSET << CF_FRAC) + (1 << (CF_FRAC - 1)));
    localparam logic signed [ACC_W-1:0] LIM = ACC_W'((1 << DATA_W) - 1);

    logic signed [PROD_W-1:0] pr_q, pg_q, pb_q;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  scaled;
    logic [DATA_W-1:0]        q_d;

    // Stage 1: register the three signed products
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr_q <= '0;
            pg_q <= '0;
            pb_q <= '0;
        end else begin
            pr_q <= PROD_W'($signed({1'b0, r})) * PROD_W'(k.kr);
            pg_q <= PROD_W'($signed({1'b0, g})) * PROD_W'(k.kg);
            pb_q <= PROD_W'($signed({1'b0, b})) * PROD_W'(k.kb);
        end
    end

    // Stage 2: sum the products with the offset and half-LSB rounding term
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else
            acc_q <= ACC_W'(pr_q) + ACC_W'(pg_q) + ACC_W'(pb_q) + BIAS;
    end

    // Floor division by the coefficient scale
    assign scaled = acc_q >>> CF_FRAC;

    // Limit the scaled value to the unsigned output range
    always_comb begin
        if (scaled[ACC_W-1])
            q_d = '0;
        else if (scaled > LIM)
            q_d = '1;
        else
            q_d = scaled[DATA_W-1:0];
    end

    // Stage 3: register the clamped component
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= q_d;
    end

    // R8: a negative sum leaves the lane as zero
    assert_clamp_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q[ACC_W-1] |=> (q == '0));
    // R8: a sum above full scale leaves the lane as all ones
    assert_clamp_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_q[ACC_W-1] && ((acc_q >>> CF_FRAC) > LIM)) |=> (q == '1));
endmodule

// File: rtl/ycc_sideband_delay.sv
// Module: fixed-depth shift register for valid and sync flags.
// Assumes: DEPTH matches the datapath register count of the lanes.
module ycc_sideband_delay #(
    parameter int DEPTH = 3,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [DEPTH];

    // Shift the flags one stage per clock; reset clears every stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/rgb_ycc_pipe.sv
// Module: top of the RGB to YCbCr converter. Three component lanes share
// one weight matrix; the sideband is delayed to match the lane latency.
// Assumes: one pixel per clock, hd_sel changes only during blanking.
module rgb_ycc_pipe
    import ycc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hd_sel,
    input  logic              in_valid,
    input  logic              in_hs,
    input  logic              in_vs,
    input  logic [DATA_W-1:0] in_r,
    input  logic [DATA_W-1:0] in_g,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic              out_hs,
    output logic              out_vs,
    output logic [DATA_W-1:0] out_y,
    output logic [DATA_W-1:0] out_cb,
    output logic [DATA_W-1:0] out_cr
);
    localparam int LANES   = 3;
    localparam int LATENCY = 3;
    localparam int MID     = 1 << (DATA_W - 1);

    coef_mat_t         coefs;
    logic [DATA_W-1:0] lane_q [LANES];
    logic [2:0]        side_out;
    logic [1:0]        warm_q;

    ycc_mode_reg mode_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .hd_sel   (hd_sel),
        .coefs    (coefs)
    );

    // One lane per output component; chroma lanes carry the mid-scale offset
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        ycc_lane #(
            .DATA_W (DATA_W),
            .OFFSET ((i == 0) ? 0 : MID)
        ) lane_i (
            .clk   (clk),
            .rst_n (rst_n),
            .k     (coefs[i]),
            .r     (in_r),
            .g     (in_g),
            .b     (in_b),
            .q     (lane_q[i])
        );
    end

    ycc_sideband_delay #(
        .DEPTH (LATENCY),
        .W     (3)
    ) side_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({in_valid, in_hs, in_vs}),
        .dout  (side_out)
    );

    assign {out_valid, out_hs, out_vs} = side_out;
    assign out_y  = lane_q[0];
    assign out_cb = lane_q[1];
    assign out_cr = lane_q[2];

    // Count edges since reset so the latency check looks back only that far
    always_ff @(posedge clk) begin
        if (!rst_n)
            warm_q <= '0;
        else if (warm_q != 2'd3)
            warm_q <= warm_q + 2'd1;
    end

    // R2: sideband outputs track the inputs three edges back
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (out_valid == $past(in_valid, 3) &&
                              out_hs == $past(in_hs, 3) &&
                              out_vs == $past(in_vs, 3)));
    // R1: an edge in reset leaves every output at zero
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_hs && !out_vs &&
                    out_y == '0 && out_cb == '0 && out_cr == '0));
endmodule

// File: tb/rgb_ycc_pipe_tb_top.sv
module rgb_ycc_pipe_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hd_sel = 1'b0;
    logic       in_valid = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
    logic [7:0] in_r = '0, in_g = '0, in_b = '0;
    logic       out_valid, out_hs, out_vs;
    logic [7:0] out_y, out_cb, out_cr;

    int n_checks = 0;
    int n_fail   = 0;

    // Expected-output history: index 2 is the pixel from three cycles ago
    bit    hv [3];
    bit    hhs[3];
    bit    hvs[3];
    int    hy [3];
    int    hcb[3];
    int    hcr[3];
    string htag[3];
    bit    bmode = 1'b0;

    rgb_ycc_pipe dut_i (
        .clk(clk), .rst_n(rst_n), .hd_sel(hd_sel),
        .in_valid(in_valid), .in_hs(in_hs), .in_vs(in_vs),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_hs(out_hs), .out_vs(out_vs),
        .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference model built from the stated weights, offset, rounding and clamp
    function automatic int ref_val(int lane, bit hd, int r, int g, int b);
        int kr, kg, kb, acc, v;
        case ({hd, 2'(lane)})
            3'b000: begin kr = 306;  kg = 601;  kb = 117; end
            3'b001: begin kr = -176; kg = -347; kb = 523; end
            3'b010: begin kr = 523;  kg = -438; kb = -85; end
            3'b100: begin kr = 218;  kg = 732;  kb = 74;  end
            3'b101: begin kr = -120; kg = -403; kb = 523; end
            default: begin kr = 523; kg = -475; kb = -48; end
        endcase
        acc = kr * r + kg * g + kb * b + ((lane == 0) ? 0 : 128 * 1024) + 512;
        v = acc >>> 10;
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        return v;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One clock of stimulus: check the pixel due now, record and drive the next
    task automatic step(bit v, bit hs, bit vs, bit hd, int r, int g, int b, string tag);
        chk("R2", "out_valid", int'(out_valid), int'(hv[2]));
        chk("R2", "out_hs", int'(out_hs), int'(hhs[2]));
        chk("R2", "out_vs", int'(out_vs), int'(hvs[2]));
        if (hv[2]) begin
            chk(htag[2], "Y", int'(out_y), hy[2]);
            chk(htag[2], "Cb", int'(out_cb), hcb[2]);
            chk(htag[2], "Cr", int'(out_cr), hcr[2]);
        end
        for (int i = 2; i > 0; i--) begin
            hv[i] = hv[i-1]; hhs[i] = hhs[i-1]; hvs[i] = hvs[i-1];
            hy[i] = hy[i-1]; hcb[i] = hcb[i-1]; hcr[i] = hcr[i-1];
            htag[i] = htag[i-1];
        end
        hv[0] = v; hhs[0] = hs; hvs[0] = vs; htag[0] = tag;
        hy[0]  = ref_val(0, bmode, r, g, b);
        hcb[0] = ref_val(1, bmode, r, g, b);
        hcr[0] = ref_val(2, bmode, r, g, b);
        if (!v) bmode = hd;
        in_valid = v; in_hs = hs; in_vs = vs; hd_sel = hd;
        in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
        @(negedge clk);
    endtask

    task automatic idle(int n, bit hd);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, hd, 0, 0, 0, "idle");
    endtask

    // R1: reset with busy inputs, check outputs zero, release with hd_sel as given
    task automatic t_reset(bit hd_at_release);
        rst_n = 1'b0;
        in_valid = 1'b1; in_hs = 1'b1; in_vs = 1'b1;
        in_r = 8'd200; in_g = 8'd100; in_b = 8'd50; hd_sel = hd_at_release;
        repeat (2) @(negedge clk);
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "out_hs", int'(out_hs), 0);
        chk("R1", "out_vs", int'(out_vs), 0);
        chk("R1", "out_y", int'(out_y), 0);
        chk("R1", "out_cb", int'(out_cb), 0);
        chk("R1", "out_cr", int'(out_cr), 0);
        for (int i = 0; i < 3; i++) begin
            hv[i] = 0; hhs[i] = 0; hvs[i] = 0; hy[i] = 0; hcb[i] = 0; hcr[i] = 0;
            htag[i] = "R1";
        end
        bmode = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_sd_colours();
        idle(1, 1'b0);
        step(1, 0, 0, 0, 255, 255, 255, "R3 R4 white");
        step(1, 0, 0, 0, 0, 0, 0, "R3 R4 black");
        step(1, 0, 0, 0, 240, 240, 0, "R3 R4 yellow");
        step(1, 0, 0, 0, 240, 0, 0, "R3 R4 red");
        step(1, 0, 0, 0, 0, 240, 0, "R3 R4 green");
        step(1, 0, 0, 0, 0, 0, 240, "R3 R4 blue");
        step(1, 0, 0, 0, 37, 150, 201, "R3 R4 mixed");
        idle(4, 1'b0);
    endtask

    task automatic t_hd_colours();
        idle(1, 1'b1);
        step(1, 0, 0, 1, 255, 255, 255, "R5 R6 white");
        step(1, 0, 0, 1, 240, 0, 0, "R5 R6 red");
        step(1, 0, 0, 1, 0, 240, 0, "R5 R6 green");
        step(1, 0, 0, 1, 0, 0, 240, "R5 R6 blue");
        step(1, 0, 0, 1, 128, 64, 32, "R5 R6 mixed");
        idle(4, 1'b1);
    endtask

    task automatic t_rounding();
        idle(1, 1'b0);
        step(1, 0, 0, 0, 1, 0, 0, "R7 below half");
        step(1, 0, 0, 0, 2, 0, 0, "R7 above half");
        step(1, 0, 0, 0, 0, 1, 1, "R7 small mix");
        step(1, 0, 0, 0, 5, 3, 0, "R7 negative chroma fraction");
        idle(4, 1'b0);
    endtask

    task automatic t_clamp();
        idle(1, 1'b0);
        step(1, 0, 0, 0, 0, 0, 255, "R8 SD Cb high");
        step(1, 0, 0, 0, 255, 255, 0, "R8 SD Cb low");
        step(1, 0, 0, 0, 255, 0, 0, "R8 SD Cr high");
        idle(1, 1'b1);
        step(1, 0, 0, 1, 0, 0, 255, "R8 HD Cb high");
        step(1, 0, 0, 1, 0, 255, 255, "R8 HD Cr low");
        idle(4, 1'b1);
    endtask

    task automatic t_sideband();
        idle(2, 1'b0);
        step(1, 0, 0, 0, 10, 20, 30, "R2 lone pixel");
        idle(2, 1'b0);
        step(0, 1, 0, 0, 0, 0, 0, "R2 hs");
        step(0, 1, 1, 0, 0, 0, 0, "R2 hs vs");
        step(0, 0, 1, 0, 0, 0, 0, "R2 vs");
        step(1, 0, 0, 0, 90, 90, 90, "R2 burst a");
        step(1, 0, 0, 0, 91, 12, 250, "R2 burst b");
        step(1, 1, 0, 0, 3, 200, 77, "R2 burst c");
        idle(4, 1'b0);
    endtask

    task automatic t_mode_hold();
        idle(1, 1'b0);
        step(1, 0, 0, 0, 200, 50, 100, "R9 before toggle");
        step(1, 0, 0, 1, 200, 50, 100, "R9 toggle in line");
        step(1, 0, 0, 1, 10, 240, 30, "R9 still SD");
        step(1, 0, 0, 0, 10, 240, 30, "R9 toggle back");
        step(1, 0, 0, 1, 10, 240, 30, "R9 still SD again");
        step(0, 0, 0, 1, 0, 0, 0, "R9 blank load");
        step(1, 0, 0, 0, 10, 240, 30, "R9 now HD");
        step(1, 0, 0, 0, 200, 50, 100, "R9 HD held");
        idle(4, 1'b0);
        // Reset with hd_sel high and stream at once: matrix must be SD
        t_reset(1'b1);
        step(1, 0, 0, 1, 10, 240, 30, "R9 reset default");
        step(1, 0, 0, 1, 200, 50, 100, "R9 reset default b");
        idle(4, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset(1'b0);
        t_sd_colours();
        t_hd_colours();
        t_rounding();
        t_clamp();
        t_sideband();
        t_mode_hold();
        // R1: reset in the middle of a stream
        step(1, 1, 1, 0, 50, 60, 70, "R1 pre-reset");
        t_reset(1'b0);
        idle(4, 1'b0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule